// File: doc/BRIEF.md
# Composite Video Sync Timing Generator

This block produces the active-low composite sync waveform of an interlace-style raster. A free-running counter runs through one line at a time. At the top of each line the output drops low. It rises again when the counter reaches that line's sync-end compare value. The line ends when the counter reaches the line's period. Each line therefore carries exactly one pulse.

The period and the compare value are held in active registers. Each has a shadow copy in front of it. A sequencer loads the shadow pair with the settings for the following line during the current line. The shadow pair moves into the active pair only at the counter wrap, so the values change at a line boundary and never partway through a line.

The frame is a list of entries. An entry is either a full-length picture line or a half-length line used in the vertical interval. A vertical-interval line that needs two pulses is built as two consecutive half-lines, so no line ever needs a second compare. The block reports these events:
- a strobe on the first cycle of every line,
- the index of the current entry,
- a flag on the first line of each frame.

Top module: `csync_gen`

## Requirements
- R1: While `rst` is high, `sync_n` is 1 and `line_start` and `frame_start` are 0. On the first cycle after `rst` falls, entry 0 begins with `sync_n`=0, `line_start`=1, `frame_start`=1 and `line_idx`=0.
- R2: Every line begins with a falling edge of `sync_n`. `sync_n` is 1 in the last cycle of the previous line and 0 in the cycle where `line_start` is 1.
- R3: Within a line, `sync_n` is low for exactly the entry's compare count of cycles, counted from the first cycle. It is then high until the line ends, giving one pulse per line.
- R4: A picture line lasts `PER_FULL` cycles (default 2048) with a low time of `SYNC_NORM` (default 150).
- R5: An equalising half-line lasts `PER_FULL`/2 cycles (default 1024) with a low time of `SYNC_EQ` (default 75).
- R6: A broad half-line lasts `PER_FULL`/2 cycles with a low time of `SYNC_BROAD` (default 874).
- R7: The entries follow this fixed order: `EQ_PRE` equalising half-lines, then `BROAD_N` broad half-lines, then `EQ_POST` equalising half-lines, then `ACTIVE_N` picture lines. `line_idx` stays constant through a line and rises by one at each wrap. After the last entry it returns to 0.
- R8: `line_start` is 1 for exactly one cycle, on the first cycle of each line.
- R9: `frame_start` is 1 only together with `line_start`, and only when the new line's index is 0.
- R10: The period and compare value in force are held for the whole line. Values staged for the next line take effect only at the wrap. This includes the wrap from the last entry back to entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | output | 1 | Composite sync, active low |
| line_start | output | 1 | One-cycle strobe on the first cycle of each line |
| frame_start | output | 1 | High with `line_start` when entry 0 begins |
| line_idx | output | IDX_W | Index of the entry being output |

## Verification
Several events fall in the same cycle when the last entry of a frame wraps:
- the shadow-to-active transfer,
- the index returning to zero,
- the frame flag,
- the falling sync edge.

The bench runs two full frames back to back, so this coincidence occurs in the middle of the run. The line after it is judged on three things: its period and low time must be those of entry 0, `frame_start` must be set, and `sync_n` must have been high one cycle earlier. A reset in the middle of a line then checks that the active and shadow registers both restart from entry 0 and not from stale staged values.

// File: rtl/csync_pkg.sv
`timescale 1ns/1ps
package csync_pkg;

   typedef enum logic [1:0] {
      SEG_EQUAL  = 2'd0,
      SEG_BROAD  = 2'd1,
      SEG_NORMAL = 2'd2
   } seg_kind_e;

   // Segment kind of entry i, given the sizes of the vertical-interval groups.
   function automatic seg_kind_e kind_of(input int i, input int pre_n,
                                         input int broad_n, input int post_n);
      seg_kind_e k;
      if (i < pre_n)                          k = SEG_EQUAL;
      else if (i < pre_n + broad_n)           k = SEG_BROAD;
      else if (i < pre_n + broad_n + post_n)  k = SEG_EQUAL;
      else                                    k = SEG_NORMAL;
      return k;
   endfunction

endpackage

// File: rtl/csync_table.sv
`timescale 1ns/1ps
module csync_table #(
   parameter int PER_W      = 12,
   parameter int IDX_W      = 6,
   parameter int N_LINES    = 35,
   parameter int EQ_PRE     = 5,
   parameter int BROAD_N    = 5,
   parameter int EQ_POST    = 5,
   parameter int PER_FULL   = 2048,
   parameter int SYNC_NORM  = 150,
   parameter int SYNC_EQ    = 75,
   parameter int SYNC_BROAD = 874,
   parameter bit USE_ROM    = 1'b1
) (
   input  logic [IDX_W-1:0] idx,
   output logic [PER_W-1:0] per,
   output logic [PER_W-1:0] cmp
);
   import csync_pkg::*;

   localparam int SLOTS    = 1 << IDX_W;
   localparam int PER_HALF = PER_FULL / 2;

   function automatic logic [PER_W-1:0] per_of(input int i);
      return (kind_of(i, EQ_PRE, BROAD_N, EQ_POST) == SEG_NORMAL) ?
             PER_W'(PER_FULL) : PER_W'(PER_HALF);
   endfunction

   function automatic logic [PER_W-1:0] cmp_of(input int i);
      logic [PER_W-1:0] v;
      case (kind_of(i, EQ_PRE, BROAD_N, EQ_POST))
         SEG_BROAD:  v = PER_W'(SYNC_BROAD);
         SEG_EQUAL:  v = PER_W'(SYNC_EQ);
         default:    v = PER_W'(SYNC_NORM);
      endcase
      return v;
   endfunction

   generate
      if (USE_ROM) begin : g_rom
         logic [PER_W-1:0] rom_per [SLOTS];
         logic [PER_W-1:0] rom_cmp [SLOTS];
         for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            if (i < N_LINES) begin : g_used
               assign rom_per[i] = per_of(i);
               assign rom_cmp[i] = cmp_of(i);
            end else begin : g_spare
               assign rom_per[i] = PER_W'(PER_FULL);
               assign rom_cmp[i] = PER_W'(SYNC_NORM);
            end
         end
         assign per = rom_per[idx];
         assign cmp = rom_cmp[idx];
      end else begin : g_decode
         always_comb begin
            per = per_of(int'(idx));
            cmp = cmp_of(int'(idx));
         end
      end
   endgenerate

endmodule

// File: rtl/csync_line_timer.sv
`timescale 1ns/1ps
module csync_line_timer #(
   parameter int PER_W = 12
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stage_en,
   input  logic [PER_W-1:0] stage_per,
   input  logic [PER_W-1:0] stage_cmp,
   input  logic [PER_W-1:0] init_per,
   input  logic [PER_W-1:0] init_cmp,
   output logic             wrap,
   output logic [PER_W-1:0] cnt,
   output logic [PER_W-1:0] act_per,
   output logic [PER_W-1:0] act_cmp,
   output logic             sync_n,
   output logic             line_start
);
   logic [PER_W-1:0] cnt_q, per_q, cmp_q, sh_per_q, sh_cmp_q;

   assign wrap = (cnt_q == per_q - PER_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         per_q    <= init_per;
         cmp_q    <= init_cmp;
         sh_per_q <= init_per;
         sh_cmp_q <= init_cmp;
      end else begin
         if (wrap) begin
            cnt_q <= '0;
            per_q <= sh_per_q;
            cmp_q <= sh_cmp_q;
         end else begin
            cnt_q <= cnt_q + PER_W'(1);
         end
         if (stage_en) begin
            sh_per_q <= stage_per;
            sh_cmp_q <= stage_cmp;
         end
      end
   end

   assign cnt        = cnt_q;
   assign act_per    = per_q;
   assign act_cmp    = cmp_q;
   assign sync_n     = rst | (cnt_q >= cmp_q);
   assign line_start = ~rst & (cnt_q == '0);

endmodule

// File: rtl/csync_sequencer.sv
`timescale 1ns/1ps
module csync_sequencer #(
   parameter int IDX_W   = 6,
   parameter int N_LINES = 35
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wrap,
   output logic [IDX_W-1:0] cur_idx,
   output logic [IDX_W-1:0] ahead_idx,
   output logic             stage_en
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LINES - 1);

   logic [IDX_W-1:0] idx_q;
   logic             stage_q;

   assign ahead_idx = (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q   <= '0;
         stage_q <= 1'b1;
      end else begin
         stage_q <= wrap;
         if (wrap) idx_q <= ahead_idx;
      end
   end

   assign cur_idx  = idx_q;
   assign stage_en = stage_q;

endmodule

// File: rtl/csync_gen.sv
`timescale 1ns/1ps
module csync_gen #(
   parameter int PER_FULL   = 2048,
   parameter int SYNC_NORM  = 150,
   parameter int SYNC_EQ    = 75,
   parameter int SYNC_BROAD = 874,
   parameter int EQ_PRE     = 5,
   parameter int BROAD_N    = 5,
   parameter int EQ_POST    = 5,
   parameter int ACTIVE_N   = 20,
   parameter bit USE_ROM    = 1'b1,
   localparam int N_LINES   = EQ_PRE + BROAD_N + EQ_POST + ACTIVE_N,
   localparam int IDX_W     = (N_LINES > 1) ? $clog2(N_LINES) : 1,
   localparam int PER_W     = $clog2(PER_FULL + 1)
) (
   input  logic             clk,
   input  logic             rst,
   output logic             sync_n,
   output logic             line_start,
   output logic             frame_start,
   output logic [IDX_W-1:0] line_idx
);
   initial begin
      assert (PER_FULL >= 4 && PER_FULL % 2 == 0)
         else $error("PER_FULL must be even and at least 4");
      assert (SYNC_NORM > 0 && SYNC_NORM < PER_FULL)
         else $error("SYNC_NORM out of range");
      assert (SYNC_EQ > 0 && SYNC_EQ < PER_FULL / 2)
         else $error("SYNC_EQ out of range");
      assert (SYNC_BROAD > 0 && SYNC_BROAD < PER_FULL / 2)
         else $error("SYNC_BROAD out of range");
      assert (N_LINES >= 2) else $error("frame needs two entries or more");
   end

   logic             wrap_w, stage_w;
   logic [IDX_W-1:0] cur_idx_w, ahead_idx_w;
   logic [PER_W-1:0] stage_per_w, stage_cmp_w, init_per_w, init_cmp_w;
   logic [PER_W-1:0] cnt_w, act_per_w, act_cmp_w;

   csync_sequencer #(.IDX_W(IDX_W), .N_LINES(N_LINES)) u_seq (
      .clk(clk), .rst(rst), .wrap(wrap_w),
      .cur_idx(cur_idx_w), .ahead_idx(ahead_idx_w), .stage_en(stage_w)
   );

   csync_table #(
      .PER_W(PER_W), .IDX_W(IDX_W), .N_LINES(N_LINES),
      .EQ_PRE(EQ_PRE), .BROAD_N(BROAD_N), .EQ_POST(EQ_POST),
      .PER_FULL(PER_FULL), .SYNC_NORM(SYNC_NORM), .SYNC_EQ(SYNC_EQ),
      .SYNC_BROAD(SYNC_BROAD), .USE_ROM(USE_ROM)
   ) u_tab_ahead (
      .idx(ahead_idx_w), .per(stage_per_w), .cmp(stage_cmp_w)
   );

   csync_table #(
      .PER_W(PER_W), .IDX_W(IDX_W), .N_LINES(N_LINES),
      .EQ_PRE(EQ_PRE), .BROAD_N(BROAD_N), .EQ_POST(EQ_POST),
      .PER_FULL(PER_FULL), .SYNC_NORM(SYNC_NORM), .SYNC_EQ(SYNC_EQ),
      .SYNC_BROAD(SYNC_BROAD), .USE_ROM(USE_ROM)
   ) u_tab_first (
      .idx('0), .per(init_per_w), .cmp(init_cmp_w)
   );

   csync_line_timer #(.PER_W(PER_W)) u_timer (
      .clk(clk), .rst(rst),
      .stage_en(stage_w), .stage_per(stage_per_w), .stage_cmp(stage_cmp_w),
      .init_per(init_per_w), .init_cmp(init_cmp_w),
      .wrap(wrap_w), .cnt(cnt_w), .act_per(act_per_w), .act_cmp(act_cmp_w),
      .sync_n(sync_n), .line_start(line_start)
   );

   assign line_idx    = cur_idx_w;
   assign frame_start = line_start & (cur_idx_w == '0);

endmodule

// File: rtl/csync_gen_chk.sv
`timescale 1ns/1ps
module csync_gen_chk #(
   parameter int PER_W   = 12,
   parameter int IDX_W   = 6,
   parameter int N_LINES = 35
) (
   input logic             clk,
   input logic             rst,
   input logic             sync_n,
   input logic             line_start,
   input logic             frame_start,
   input logic [IDX_W-1:0] line_idx,
   input logic [PER_W-1:0] cnt,
   input logic [PER_W-1:0] act_per,
   input logic [PER_W-1:0] act_cmp
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_LINES - 1);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |-> (sync_n && !line_start && !frame_start));

   assert_fall_at_start_R2: assert property (@(posedge clk) disable iff (rst)
      line_start |-> !sync_n);

   assert_one_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      (sync_n && !line_start) |=> (sync_n || line_start));

   assert_index_step_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt == act_per - PER_W'(1)) |=>
      (line_idx == (($past(line_idx) == LAST) ? '0 : $past(line_idx) + IDX_W'(1))));

   assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
      line_start |=> !line_start);

   assert_frame_flag_R9: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (line_start && line_idx == '0));

   assert_active_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (cnt != act_per - PER_W'(1)) |=> ($stable(act_per) && $stable(act_cmp)));

endmodule

bind csync_gen csync_gen_chk #(
   .PER_W(PER_W), .IDX_W(IDX_W), .N_LINES(N_LINES)
) chk_i (
   .clk(clk), .rst(rst), .sync_n(sync_n), .line_start(line_start),
   .frame_start(frame_start), .line_idx(line_idx),
   .cnt(cnt_w), .act_per(act_per_w), .act_cmp(act_cmp_w)
);

// File: tb/csync_gen_tb_top.sv
`timescale 1ns/1ps
module csync_gen_tb_top;
   localparam int PER_FULL = 2048, SYNC_NORM = 150, SYNC_EQ = 75, SYNC_BROAD = 874;
   localparam int EQ_PRE = 5, BROAD_N = 5, EQ_POST = 5, ACTIVE_N = 20;
   localparam int NL = EQ_PRE + BROAD_N + EQ_POST + ACTIVE_N;
   localparam int IW = $clog2(NL);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sync_n, line_start, frame_start;
   logic [IW-1:0] line_idx;

   always #5 clk = ~clk;

   csync_gen dut_i (
      .clk(clk), .rst(rst), .sync_n(sync_n), .line_start(line_start),
      .frame_start(frame_start), .line_idx(line_idx)
   );

   typedef struct { int idx; int per; int cmp; string tag; } exp_t;
   exp_t q[$];

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Expected entry from the requirement text (R4, R5, R6, R7).
   function automatic exp_t model(input int i);
      exp_t e;
      e.idx = i;
      if (i < EQ_PRE || (i >= EQ_PRE + BROAD_N && i < EQ_PRE + BROAD_N + EQ_POST)) begin
         e.per = PER_FULL / 2; e.cmp = SYNC_EQ; e.tag = "R5";
      end else if (i < EQ_PRE + BROAD_N) begin
         e.per = PER_FULL / 2; e.cmp = SYNC_BROAD; e.tag = "R6";
      end else begin
         e.per = PER_FULL; e.cmp = SYNC_NORM; e.tag = "R4";
      end
      return e;
   endfunction

   task automatic push_lines(input int first, input int count);
      for (int k = 0; k < count; k++) q.push_back(model((first + k) % NL));
   endtask

   // Monitor: measures each line and compares against the scoreboard.
   bit have = 1'b0, split = 1'b0, went_high = 1'b0, idx_chg = 1'b0;
   bit fs_seen = 1'b0, fall_ok = 1'b0, prev_sync = 1'b1, prev_ls = 1'b0;
   int len = 0, low = 0, idx_seen = 0;

   always @(negedge clk) begin
      if (rst) begin
         have = 1'b0;
      end else if (line_start) begin
         chk(!prev_ls, "R8 strobe longer than one cycle", int'(prev_ls), 0);
         if (have && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(len == e.per, {e.tag, "/R10 period"}, len, e.per);
            chk(low == e.cmp, {e.tag, "/R3 low time"}, low, e.cmp);
            chk(!split, "R3 second pulse in line", int'(split), 0);
            chk(idx_seen == e.idx && !idx_chg, "R7 line index", idx_seen, e.idx);
            chk(fs_seen == (e.idx == 0), "R9 frame_start", int'(fs_seen), int'(e.idx == 0));
            chk(fall_ok, "R2 falling edge at line start", int'(fall_ok), 1);
         end
         have      = 1'b1;
         len       = 1;
         low       = sync_n ? 0 : 1;
         went_high = sync_n;
         split     = 1'b0;
         idx_chg   = 1'b0;
         idx_seen  = int'(line_idx);
         fs_seen   = frame_start;
         fall_ok   = !sync_n && prev_sync;
      end else if (have) begin
         len++;
         if (!sync_n) begin
            low++;
            if (went_high) split = 1'b1;
         end else begin
            went_high = 1'b1;
         end
         if (int'(line_idx) != idx_seen) idx_chg = 1'b1;
         if (frame_start) chk(1'b0, "R9 frame_start without strobe", 1, 0);
      end
      prev_sync = sync_n;
      prev_ls   = line_start;
   end

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
      report();
   end

   initial begin
      rst = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(sync_n == 1'b1, "R1 sync high in reset", int'(sync_n), 1);
      chk(line_start == 1'b0 && frame_start == 1'b0, "R1 strobes low in reset",
          int'(line_start) + int'(frame_start), 0);
      push_lines(0, 2 * NL);
      @(posedge clk); #2 rst = 1'b0;
      @(negedge clk);
      chk(sync_n == 1'b0, "R1 first cycle sync low", int'(sync_n), 0);
      chk(line_start && frame_start, "R1 first cycle strobes",
          int'(line_start) + int'(frame_start), 2);
      chk(line_idx == '0, "R1 first cycle index", int'(line_idx), 0);
      while (q.size() != 0) @(negedge clk);

      // Reset in the middle of a line: both register copies restart at entry 0.
      repeat (300) @(negedge clk);
      @(posedge clk); #2 rst = 1'b1;
      repeat (3) @(negedge clk);
      chk(sync_n == 1'b1 && !line_start, "R1 mid-line reset quiet",
          int'(sync_n) - int'(line_start), 1);
      push_lines(0, 3);
      @(posedge clk); #2 rst = 1'b0;
      @(negedge clk);
      chk(line_idx == '0 && frame_start && !sync_n, "R1 restart at entry 0",
          int'(line_idx), 0);
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
      report();
   end

endmodule